// File: doc/BRIEF.md
# Raster Beam Position Counter

This block tracks where the beam of a raster display is, as a horizontal position within the line and a vertical line number within the frame. A pixel-step enable advances the horizontal count by one. At the end of each line the horizontal count wraps to zero and the line number advances. The horizontal count does not run straight from zero to its top. It climbs to the end of the active region and then jumps forward into a high range, ending at 0x1FF. Where that jump happens depends on the selected line width: a narrow 32-cell layout or a wide 40-cell layout. The number of lines per frame depends on the selected video standard.

Software and other logic read three things. The first is an 8-bit horizontal value, which is the 9-bit internal count halved. The second is an 8-bit vertical value, which is the low byte of the line number. The third is a status word whose vertical-blank bit is set from line 224 to the end of the frame. A packed 16-bit word carries the vertical and horizontal bytes together, so one read gives both. All pins are plain control and status; there is no streamed data and no handshake. Every output follows the counters in the same cycle they change.

Top module: `raster_pos_counter`

## Requirements
- R1: With `wide_mode`=1 the internal horizontal count steps 0x000..0x16C, then 0x1C9..0x1FF, then 0x000, for 420 steps per line.
- R2: With `wide_mode`=0 the internal horizontal count steps 0x000..0x127, then 0x1D2..0x1FF, then 0x000, for 342 steps per line.
- R3: `h_pos` equals the internal horizontal count shifted right by one bit (for example 0x16C reads 0xB6 and 0x1C9 reads 0xE4).
- R4: While `pix_en` is 0, neither count changes, whatever the mode inputs do.
- R5: If a step starts from a count at or beyond the active end of the currently selected mode but below that mode's resume value (possible after a mode change), the count goes to the resume value (0x1D2 narrow, 0x1C9 wide).
- R6: The line number advances by one on exactly the step that takes the horizontal count from 0x1FF to 0x000, and holds otherwise.
- R7: With `pal_mode`=0 a frame has 262 lines (0..261); with `pal_mode`=1 it has 313 lines (0..312). The step after the last line returns the line number to 0.
- R8: `v_pos` is the low 8 bits of the line number, so line 256 reads 0x00 and line 312 reads 0x38.
- R9: `status` bit 3 is 1 while the line number is 224 or higher and 0 otherwise; all other status bits are 0.
- R10: `hv_word` carries `v_pos` in bits 15:8 and `h_pos` in bits 7:0.
- R11: While `rst_n` is low, both counts are 0, and `h_pos`, `v_pos`, `hv_word` and `status` all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Advances the horizontal count by one step on a rising edge |
| wide_mode | input | 1 | 1 selects the 40-cell line layout, 0 the 32-cell layout |
| pal_mode | input | 1 | 1 selects 313 lines per frame, 0 selects 262 |
| h_pos | output | 8 | Horizontal position, internal count halved |
| v_pos | output | 8 | Low byte of the line number |
| hv_word | output | 16 | Vertical byte above horizontal byte |
| status | output | 16 | Status word, vertical blank in bit 3 |

## Verification
The horizontal value changes on the same rising edge that samples `pix_en` high. The line number and the blank bit change on that same edge when it is the wrapping step, with no extra register stage in between. After the bench applies n steps, the outputs are therefore due right after the n-th rising edge. The bench drives `pix_en` and the mode pins on falling edges, counts the rising edges that see an enable, and samples on the following falling edge. Line-level checks use whole multiples of the 342-step narrow line, so each expected line number and blank state falls out of the step count alone.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int HCNT_W   = 9;
  localparam int VCNT_W   = 9;
  localparam int BYTE_W   = 8;
  localparam int STAT_W   = 16;
  localparam int VB_BIT   = 3;

  typedef logic [HCNT_W-1:0] hcnt_t;
  typedef logic [VCNT_W-1:0] vcnt_t;
  typedef logic [BYTE_W-1:0] pos_byte_t;

  // one horizontal layout: last active count and the count it resumes at
  typedef struct packed {
    hcnt_t last_active;
    hcnt_t resume;
  } hseg_t;
endpackage

// File: rtl/rpc_hcount.sv
module rpc_hcount
  import rpc_pkg::*;
#(
  parameter int NARROW_LAST   = 'h127,
  parameter int NARROW_RESUME = 'h1D2,
  parameter int WIDE_LAST     = 'h16C,
  parameter int WIDE_RESUME   = 'h1C9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pix_en,
  input  logic  wide_mode,
  output hcnt_t hcnt,
  output logic  line_wrap
);
  localparam hcnt_t H_END = '1;

  hseg_t seg_tab [2];
  hseg_t seg_sel;
  logic  in_gap;
  hcnt_t hcnt_nxt;

  assign seg_tab[0] = '{last_active: hcnt_t'(NARROW_LAST), resume: hcnt_t'(NARROW_RESUME)};
  assign seg_tab[1] = '{last_active: hcnt_t'(WIDE_LAST),   resume: hcnt_t'(WIDE_RESUME)};
  assign seg_sel    = seg_tab[wide_mode];

  // covers the normal jump and any count stranded by a layout change
  assign in_gap    = (hcnt >= seg_sel.last_active) && (hcnt < seg_sel.resume);
  assign line_wrap = pix_en && (hcnt == H_END);

  always_comb begin
    hcnt_nxt = hcnt;
    if (pix_en) begin
      if (hcnt == H_END)  hcnt_nxt = '0;
      else if (in_gap)    hcnt_nxt = seg_sel.resume;
      else                hcnt_nxt = hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hcnt <= '0;
    else        hcnt <= hcnt_nxt;
  end

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hcnt == H_END) |=> (hcnt == '0)); // R1
  AST_H_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hcnt == seg_sel.last_active) |=> (hcnt == $past(seg_sel.resume))); // R5
  AST_H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en) |=> $stable(hcnt)); // R4
endmodule

// File: rtl/rpc_vcount.sv
module rpc_vcount
  import rpc_pkg::*;
#(
  parameter int LINES_NTSC = 262,
  parameter int LINES_PAL  = 313
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_wrap,
  input  logic  pal_mode,
  output vcnt_t vcnt
);
  localparam vcnt_t LAST_NTSC = vcnt_t'(LINES_NTSC - 1);
  localparam vcnt_t LAST_PAL  = vcnt_t'(LINES_PAL - 1);
  localparam vcnt_t LAST_MAX  = (LAST_PAL > LAST_NTSC) ? LAST_PAL : LAST_NTSC;

  vcnt_t last_line;
  logic  at_end;

  assign last_line = pal_mode ? LAST_PAL : LAST_NTSC;
  // at-or-beyond, so a standard switch late in a frame still wraps
  assign at_end    = (vcnt >= last_line);

  always_ff @(posedge clk) begin
    if (!rst_n)          vcnt <= '0;
    else if (line_wrap)  vcnt <= at_end ? '0 : vcnt + 1'b1;
  end

  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_wrap) |=> $stable(vcnt)); // R6
  AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wrap && vcnt < last_line) |=> (vcnt == vcnt_t'($past(vcnt) + 1'b1))); // R6
  AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wrap && vcnt >= last_line) |=> (vcnt == '0)); // R7
  AST_V_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt <= LAST_MAX)); // R7
endmodule

// File: rtl/rpc_status.sv
module rpc_status
  import rpc_pkg::*;
#(
  parameter int BLANK_LINE = 224
) (
  input  logic                clk,
  input  logic                rst_n,
  input  hcnt_t               hcnt,
  input  vcnt_t               vcnt,
  output pos_byte_t           h_pos,
  output pos_byte_t           v_pos,
  output logic [2*BYTE_W-1:0] hv_word,
  output logic [STAT_W-1:0]   status
);
  localparam vcnt_t BLANK_START = vcnt_t'(BLANK_LINE);

  logic vblank;

  assign vblank  = (vcnt >= BLANK_START);
  assign h_pos   = hcnt[HCNT_W-1 -: BYTE_W];
  assign v_pos   = vcnt[BYTE_W-1:0];
  assign hv_word = {v_pos, h_pos};

  always_comb begin
    status         = '0;
    status[VB_BIT] = vblank;
  end

  AST_VB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> (vcnt == BLANK_START)); // R9
  AST_VB_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> (vcnt == '0)); // R9
endmodule

// File: rtl/raster_pos_counter.sv
module raster_pos_counter
  import rpc_pkg::*;
#(
  parameter int NARROW_LAST   = 'h127,
  parameter int NARROW_RESUME = 'h1D2,
  parameter int WIDE_LAST     = 'h16C,
  parameter int WIDE_RESUME   = 'h1C9,
  parameter int LINES_NTSC    = 262,
  parameter int LINES_PAL     = 313,
  parameter int BLANK_LINE    = 224
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_en,
  input  logic        wide_mode,
  input  logic        pal_mode,
  output logic [7:0]  h_pos,
  output logic [7:0]  v_pos,
  output logic [15:0] hv_word,
  output logic [15:0] status
);
  hcnt_t hcnt;
  vcnt_t vcnt;
  logic  line_wrap;

  rpc_hcount #(
    .NARROW_LAST  (NARROW_LAST),
    .NARROW_RESUME(NARROW_RESUME),
    .WIDE_LAST    (WIDE_LAST),
    .WIDE_RESUME  (WIDE_RESUME)
  ) u_hcount (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_en   (pix_en),
    .wide_mode(wide_mode),
    .hcnt     (hcnt),
    .line_wrap(line_wrap)
  );

  rpc_vcount #(
    .LINES_NTSC(LINES_NTSC),
    .LINES_PAL (LINES_PAL)
  ) u_vcount (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_wrap(line_wrap),
    .pal_mode (pal_mode),
    .vcnt     (vcnt)
  );

  rpc_status #(
    .BLANK_LINE(BLANK_LINE)
  ) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .hcnt   (hcnt),
    .vcnt   (vcnt),
    .h_pos  (h_pos),
    .v_pos  (v_pos),
    .hv_word(hv_word),
    .status (status)
  );
endmodule

// File: tb/test_raster_pos_counter.sv
module test_raster_pos_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NARROW_LINE = 342;
  localparam int WATCHDOG = 199_500;

  // {wide, steps to apply, expected h_pos, expected v_pos}
  localparam int NVEC = 18;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd1, 16'd1,   8'h00, 8'h00},
    {8'd1, 16'd1,   8'h01, 8'h00},
    {8'd1, 16'd362, 8'hB6, 8'h00},
    {8'd1, 16'd1,   8'hE4, 8'h00},
    {8'd1, 16'd1,   8'hE5, 8'h00},
    {8'd1, 16'd53,  8'hFF, 8'h00},
    {8'd1, 16'd1,   8'h00, 8'h01},
    {8'd0, 16'd295, 8'h93, 8'h01},
    {8'd0, 16'd1,   8'hE9, 8'h01},
    {8'd0, 16'd45,  8'hFF, 8'h01},
    {8'd0, 16'd1,   8'h00, 8'h02},
    {8'd1, 16'd320, 8'hA0, 8'h02},
    {8'd0, 16'd1,   8'hE9, 8'h02},
    {8'd0, 16'd45,  8'hFF, 8'h02},
    {8'd1, 16'd1,   8'h00, 8'h03},
    {8'd0, 16'd200, 8'h64, 8'h03},
    {8'd1, 16'd200, 8'hF6, 8'h03},
    {8'd1, 16'd0,   8'hF6, 8'h03}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        wide_mode = 1'b0;
  logic        pal_mode = 1'b0;
  logic [7:0]  h_pos;
  logic [7:0]  v_pos;
  logic [15:0] hv_word;
  logic [15:0] status;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_pos_counter i_raster_pos_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_en   (pix_en),
    .wide_mode(wide_mode),
    .pal_mode (pal_mode),
    .h_pos    (h_pos),
    .v_pos    (v_pos),
    .hv_word  (hv_word),
    .status   (status)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after n enabled rising edges
  task automatic step(input int n);
    if (n > 0) begin
      pix_en = 1'b1;
      repeat (n) @(negedge clk);
      pix_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 h_pos in reset", {8'h00, h_pos}, 16'h0000);
    chk("R11 v_pos in reset", {8'h00, v_pos}, 16'h0000);
    chk("R11 hv_word in reset", hv_word, 16'h0000);
    chk("R11 status in reset", status, 16'h0000);
    pix_en = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();

    // vector walk: layouts, halving, packing, layout switch out of the gap
    for (int i = 0; i < NVEC; i++) begin
      wide_mode = VEC[i][32];
      if (VEC[i][31:16] == 16'd0) begin
        // R4: enable held low while the mode pins toggle
        for (int k = 0; k < 10; k++) begin
          wide_mode = k[0];
          pal_mode = k[1];
          @(negedge clk);
        end
        pal_mode = 1'b0;
        chk("R4 hold h_pos", {8'h00, h_pos}, {8'h00, VEC[i][15:8]});
        chk("R4 hold v_pos", {8'h00, v_pos}, {8'h00, VEC[i][7:0]});
      end else begin
        step(int'(VEC[i][31:16]));
        if (i >= 11 && i <= 13)
          chk("R5 h_pos after layout switch", {8'h00, h_pos}, {8'h00, VEC[i][15:8]});
        else if (VEC[i][32])
          chk("R1 R3 wide h_pos", {8'h00, h_pos}, {8'h00, VEC[i][15:8]});
        else
          chk("R2 R3 narrow h_pos", {8'h00, h_pos}, {8'h00, VEC[i][15:8]});
        chk("R6 v_pos", {8'h00, v_pos}, {8'h00, VEC[i][7:0]});
        chk("R10 hv_word", hv_word, {VEC[i][7:0], VEC[i][15:8]});
      end
    end

    // 313-line frame in narrow layout
    do_reset();
    wide_mode = 1'b0;
    pal_mode = 1'b1;
    step(223 * NARROW_LINE);
    chk("R9 line 223 status", status, 16'h0000);
    chk("R6 line 223 v_pos", {8'h00, v_pos}, 16'h00DF);
    step(NARROW_LINE);
    chk("R9 line 224 status", status, 16'h0008);
    chk("R6 line 224 v_pos", {8'h00, v_pos}, 16'h00E0);
    step(32 * NARROW_LINE);
    chk("R8 line 256 v_pos", {8'h00, v_pos}, 16'h0000);
    chk("R9 line 256 status", status, 16'h0008);
    step(6 * NARROW_LINE);
    chk("R7 pal line 262 v_pos", {8'h00, v_pos}, 16'h0006);
    step(50 * NARROW_LINE);
    chk("R8 pal line 312 v_pos", {8'h00, v_pos}, 16'h0038);
    step(NARROW_LINE - 1);
    chk("R7 pal line 312 end h_pos", {8'h00, h_pos}, 16'h00FF);
    chk("R7 pal line 312 end v_pos", {8'h00, v_pos}, 16'h0038);
    step(1);
    chk("R7 pal wrap v_pos", {8'h00, v_pos}, 16'h0000);
    chk("R9 blank cleared at line 0", status, 16'h0000);
    chk("R10 hv_word at frame start", hv_word, 16'h0000);

    // 262-line frame
    pal_mode = 1'b0;
    step(261 * NARROW_LINE);
    chk("R7 ntsc line 261 v_pos", {8'h00, v_pos}, 16'h0005);
    chk("R9 ntsc line 261 status", status, 16'h0008);
    step(NARROW_LINE);
    chk("R7 ntsc wrap v_pos", {8'h00, v_pos}, 16'h0000);
    chk("R9 ntsc blank cleared", status, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule